// File: doc/BRIEF.md
# Dual Autoreload PWM Timer

This block drives a set of pulse-width-modulated outputs from two free-running up-counters. Each counter counts from its reload value up to all ones, then reloads, so the output period is set by the reload value. Each channel compares its counter with an active duty value. The output is high while the count is below that value and low from the match until the end of the period.

Software writes reload values, duty preloads, polarity and enable bits through a simple write port. The duty and polarity settings are double-buffered. A new value reaches a channel only at an overflow of the counter that drives the channel, and only when that counter's transfer flag is armed. A split bit chooses the mode. With the bit clear, every channel runs from counter A. With the bit set, the upper half of the channels runs from counter B, which has its own reload value and its own transfer flag.

Top module: `pwm_dual_timer`

## Requirements
- R1: Each counter adds one per clock. In the cycle after it holds the all-ones value (2^CW-1), it holds its reload value, so the period is 2^CW minus the reload value.
- R2: After reset, both counters, all outputs, all duty and polarity settings, all enable bits and the split bit are 0, and both transfer flags are 1.
- R3: A written duty value reaches a channel only at the first overflow of that channel's counter while that counter's transfer flag is 1. While the flag is 0, the previous active value is kept across any number of overflows.
- R4: A write to address NCH+3 with data bit 0 set arms transfer flag A, and with data bit 1 set arms flag B. Writing a 0 bit changes nothing. A flag clears at the overflow of its counter, except when an arming write lands in that same cycle, in which case the flag stays 1.
- R5: pwm_o[c] is registered. In each cycle it shows (count < active duty) XOR active polarity, as evaluated one clock earlier. A duty value at or below the reload value therefore gives a constant level and no waveform.
- R6: A polarity bit inverts its channel. Like duty, it is shadowed and takes effect only at a transfer overflow.
- R7: An enable bit at 0 forces its output to 0 from the next clock edge after the write. Enable bits are not shadowed.
- R8: With the split bit at 0, all channels use counter A, reload A and flag A. With the split bit at 1, channels NCH/2 to NCH-1 use counter B, reload B and flag B.
- R9: Write map:
  - address 0: reload A, taken from wr_data[CW-1:0];
  - address 1: reload B, taken from wr_data[CW-1:0];
  - address 2+c: duty preload of channel c, taken from wr_data[CW-1:0];
  - address NCH+2: control word, with polarity in bits [NCH-1:0], enables in bits [2NCH-1:NCH] and split in bit 2NCH.
- R10: With reload 0, duty d gives exactly d high cycles in every 2^CW. Duty 0 with inverted polarity holds the output high, which is 100% duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| pwm_o | output | NCH | Registered PWM outputs |

## Verification
The bench builds the block with CW=6, NCH=4 and DW=16, so a full period lasts only 64 clocks. This lets the bench reach the wrap from all ones, a reload of 0 at full resolution, a duty of all ones and periods as short as 10 clocks many times within a short run. Four channels make a two-channel upper half. This exercises the split mode with counter B running at a period of 20 against counter A at a period of 10. An arming write is timed to land exactly on an overflow cycle.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int ADDR_RELOAD_A = 0;
  localparam int ADDR_RELOAD_B = 1;
  localparam int ADDR_DUTY0    = 2;

  typedef enum logic {CNT_A = 1'b0, CNT_B = 1'b1} cnt_sel_e;

  function automatic int ctrl_addr(input int nch);
    return nch + 2;
  endfunction

  function automatic int xfer_addr(input int nch);
    return nch + 3;
  endfunction
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  assign ovf = (count == TOP);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (ovf) count <= reload;
    else count <= count + 1'b1;
  end
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int CW  = 12,
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [1:0]              ovf,
  output logic [1:0][CW-1:0]      reload,
  output logic [NCH-1:0][CW-1:0]  duty_pre,
  output logic [NCH-1:0]          pol_pre,
  output logic [NCH-1:0]          oe,
  output logic                    split,
  output logic [1:0]              xfer
);
  localparam logic [AW-1:0] A_CTRL = AW'(ctrl_addr(NCH));
  localparam logic [AW-1:0] A_XFER = AW'(xfer_addr(NCH));

  logic [1:0] arm;
  assign arm = (wr_en && wr_addr == A_XFER) ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload   <= '0;
      duty_pre <= '0;
      pol_pre  <= '0;
      oe       <= '0;
      split    <= 1'b0;
      xfer     <= 2'b11;
    end else begin
      for (int k = 0; k < 2; k++)
        xfer[k] <= arm[k] | (xfer[k] & ~ovf[k]);
      if (wr_en) begin
        if (wr_addr == AW'(ADDR_RELOAD_A)) reload[0] <= wr_data[CW-1:0];
        if (wr_addr == AW'(ADDR_RELOAD_B)) reload[1] <= wr_data[CW-1:0];
        for (int c = 0; c < NCH; c++)
          if (wr_addr == AW'(ADDR_DUTY0 + c)) duty_pre[c] <= wr_data[CW-1:0];
        if (wr_addr == A_CTRL) begin
          pol_pre <= wr_data[NCH-1:0];
          oe      <= wr_data[2*NCH-1:NCH];
          split   <= wr_data[2*NCH];
        end
      end
    end
  end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic          ovf,
  input  logic          xfer,
  input  logic [CW-1:0] duty_pre,
  input  logic          pol_pre,
  input  logic          oe,
  output logic          pwm
);
  logic [CW-1:0] duty_act;
  logic          pol_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      pol_act  <= 1'b0;
      pwm      <= 1'b0;
    end else begin
      pwm <= oe & ((count < duty_act) ^ pol_act);
      if (ovf && xfer) begin
        duty_act <= duty_pre;
        pol_act  <= pol_pre;
      end
    end
  end
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwmt_pkg::*;
#(
  parameter int CW  = 12,
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = $clog2(NCH + 4)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o
);
  localparam int HALF = NCH / 2;

  logic [1:0][CW-1:0]     reload;
  logic [1:0][CW-1:0]     cnt;
  logic [1:0]             ovf;
  logic [1:0]             xfer;
  logic [NCH-1:0][CW-1:0] duty_pre;
  logic [NCH-1:0]         pol_pre;
  logic [NCH-1:0]         oe;
  logic                   split;

  logic [CW-1:0] cnt_a, cnt_b, reload_a;
  logic          xfer_a;
  assign cnt_a    = cnt[0];
  assign cnt_b    = cnt[1];
  assign reload_a = reload[0];
  assign xfer_a   = xfer[0];

  pwmt_regs #(.CW(CW), .NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovf(ovf), .reload(reload), .duty_pre(duty_pre), .pol_pre(pol_pre),
    .oe(oe), .split(split), .xfer(xfer)
  );

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    pwmt_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .reload(reload[k]), .count(cnt[k]), .ovf(ovf[k])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cnt_sel_e sel;
    assign sel = (split && c >= HALF) ? CNT_B : CNT_A;
    pwmt_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst),
      .count(cnt[sel]), .ovf(ovf[sel]), .xfer(xfer[sel]),
      .duty_pre(duty_pre[c]), .pol_pre(pol_pre[c]), .oe(oe[c]),
      .pwm(pwm_o[c])
    );
  end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
  import pwmt_pkg::*;
#(
  parameter int CW  = 12,
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic [CW-1:0]  cnt_a,
  input logic [CW-1:0]  cnt_b,
  input logic [CW-1:0]  reload_a,
  input logic           xfer_a,
  input logic [NCH-1:0] oe,
  input logic [NCH-1:0] pwm_o
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [AW-1:0] A_XFER = AW'(xfer_addr(NCH));

  logic arm_a;
  assign arm_a = wr_en && (wr_addr == A_XFER) && wr_data[0];

  a_r2_reset_zero: assert property (@(posedge clk)
    rst |=> (cnt_a == '0 && cnt_b == '0 && pwm_o == '0));

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_a != TOP) |=> (cnt_a == $past(cnt_a) + 1'b1));

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_a == TOP) |=> (cnt_a == $past(reload_a)));

  a_r4_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (cnt_a == TOP && !arm_a) |=> !xfer_a);

  a_r4_flag_arm: assert property (@(posedge clk) disable iff (rst)
    arm_a |=> xfer_a);

  for (genvar c = 0; c < NCH; c++) begin : g_oe
    a_r7_oe_gate: assert property (@(posedge clk) disable iff (rst)
      !oe[c] |=> !pwm_o[c]);
  end
endmodule

bind pwm_dual_timer pwmt_checker #(.CW(CW), .NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .reload_a(reload_a), .xfer_a(xfer_a),
  .oe(oe), .pwm_o(pwm_o)
);

// File: tb/tb_pwm_dual_timer.sv
module tb_pwm_dual_timer;
  localparam int CW  = 6;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int AW  = $clog2(NCH + 4);
  localparam int TOP = (1 << CW) - 1;
  localparam int A_CTRL = NCH + 2;
  localparam int A_XFER = NCH + 3;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NCH-1:0] pwm_o;

  always #2.5 clk = ~clk;

  pwm_dual_timer #(.CW(CW), .NCH(NCH), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  int total = 0;
  int bad = 0;
  string cur = "R2";
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt [2];
  int m_rel [2];
  bit m_xf  [2];
  int m_dpre [NCH];
  int m_dact [NCH];
  bit m_pact [NCH];
  bit m_pol [NCH];
  bit m_oe  [NCH];
  bit m_split;
  bit [NCH-1:0] m_pwm;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_rel[k] = 0; m_xf[k] = 1; end
      for (int c = 0; c < NCH; c++) begin
        m_dpre[c] = 0; m_dact[c] = 0; m_pact[c] = 0; m_pol[c] = 0; m_oe[c] = 0;
      end
      m_split = 0;
      m_pwm = '0;
    end else begin
      bit ov [2];
      for (int k = 0; k < 2; k++) ov[k] = (m_cnt[k] == TOP);
      for (int c = 0; c < NCH; c++) begin
        int b;
        b = (m_split && c >= NCH / 2) ? 1 : 0;
        m_pwm[c] = m_oe[c] && ((m_cnt[b] < m_dact[c]) != m_pact[c]);
        if (ov[b] && m_xf[b]) begin
          m_dact[c] = m_dpre[c];
          m_pact[c] = m_pol[c];
        end
      end
      for (int k = 0; k < 2; k++) begin
        bit setk;
        m_cnt[k] = ov[k] ? m_rel[k] : m_cnt[k] + 1;
        setk = wr_en && (int'(wr_addr) == A_XFER) && wr_data[k];
        m_xf[k] = setk ? 1'b1 : (ov[k] ? 1'b0 : m_xf[k]);
      end
      if (wr_en) begin
        if (wr_addr == 0) m_rel[0] = int'(wr_data[CW-1:0]);
        if (wr_addr == 1) m_rel[1] = int'(wr_data[CW-1:0]);
        for (int c = 0; c < NCH; c++)
          if (int'(wr_addr) == 2 + c) m_dpre[c] = int'(wr_data[CW-1:0]);
        if (int'(wr_addr) == A_CTRL) begin
          for (int c = 0; c < NCH; c++) begin
            m_pol[c] = wr_data[c];
            m_oe[c]  = wr_data[NCH + c];
          end
          m_split = wr_data[2*NCH];
        end
      end
    end
    started = 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      total++;
      if (pwm_o !== m_pwm) begin
        bad++;
        $display("FAIL %s cycle compare: pwm_o=%b expected=%b", cur, pwm_o, m_pwm);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_addr = AW'(addr);
    wr_data = DW'(data);
    wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic highs(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_o[ch]);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    check("R2 reset outputs", int'(pwm_o), 0);
    rst = 0;

    // R9 map, R10 full resolution with reload 0
    cur = "R9";
    wr(0, 0);
    wr(2, 20);
    wr(3, 63);
    wr(4, 0);
    wr(5, 40);
    wr(A_CTRL, 32'hF0);
    repeat (140) @(negedge clk);
    cur = "R10";
    highs(0, 64, h); check("R10 duty 20 of 64", h, 20);
    highs(1, 64, h); check("R10 duty all ones", h, 63);
    cur = "R5";
    highs(2, 64, h); check("R5 duty 0 constant low", h, 0);

    // R3 no transfer without armed flag
    cur = "R3";
    wr(2, 30);
    repeat (140) @(negedge clk);
    highs(0, 64, h); check("R3 duty held while flag clear", h, 20);
    wr(A_XFER, 1);
    repeat (140) @(negedge clk);
    highs(0, 64, h); check("R3 duty after armed overflow", h, 30);

    // R1 reload gives period 10
    cur = "R1";
    wr(0, 54);
    wr(2, 60);
    wr(A_XFER, 1);
    repeat (150) @(negedge clk);
    highs(0, 10, h); check("R1 period 10 duty 60", h, 6);
    cur = "R5";
    highs(3, 10, h); check("R5 duty below reload no waveform", h, 0);

    // R6 polarity inversion, shadowed
    cur = "R6";
    wr(A_CTRL, 32'hF4);
    wr(A_XFER, 1);
    repeat (30) @(negedge clk);
    highs(2, 10, h); check("R6 inverted duty 0 full high", h, 10);

    // R8 split onto counter B
    cur = "R8";
    wr(1, 44);
    wr(5, 50);
    wr(A_CTRL, 32'h1F4);
    wr(A_XFER, 2);
    repeat (150) @(negedge clk);
    highs(3, 20, h); check("R8 channel 3 on counter B", h, 6);
    highs(2, 20, h); check("R8 channel 2 on counter B inverted", h, 20);

    // R4 writing zero has no effect, arming on the overflow cycle survives
    cur = "R4";
    wr(A_XFER, 0);
    repeat (30) @(negedge clk);
    while (m_cnt[0] != TOP) @(negedge clk);
    wr(A_XFER, 1);
    wr(2, 58);
    repeat (30) @(negedge clk);
    highs(0, 10, h); check("R4 flag kept by same-cycle arm", h, 4);

    // R7 enable off takes effect next clock
    cur = "R7";
    wr(A_CTRL, 32'h1D4);
    @(negedge clk);
    check("R7 disabled output low", int'(pwm_o[1]), 0);
    highs(1, 64, h); check("R7 disabled stays low", h, 0);

    finish_run();
  end
endmodule